// File: doc/BRIEF.md
# SAR ADC Four-Wire Capture Controller

This block runs one conversion-and-readout cycle on a serial successive-approximation converter wired in four-wire mode. A start request raises the convert strobe. The strobe then stays high for the whole cycle. The controller first waits out the conversion time with the active-low select line held inactive and the serial clock idle. The wait length is chosen by a turbo input that is sampled when the cycle starts.

After the wait, the controller asserts select and clocks in one result word, most significant bit first. It then releases select. One cycle later it drops the convert strobe and presents the result on a parallel output, together with a one-cycle done pulse. Results wider than 16 bits go into a 32-bit container; narrower results go into a 16-bit container. A signed result is sign-extended to fill its container and an unsigned result is zero-extended.

The conversion waits are given in nanoseconds and the system clock period in picoseconds. The block converts each wait into whole clock cycles, rounding up. The serial clock runs at the system clock divided by twice the half-period parameter. It idles low; the converter launches data on its rising edge and the controller samples on its falling edge.

Top module: `sar4w_capture`

## Requirements
- R1: While reset is held and right after it, cnv_o is 0, cs_no is 1, sclk_o is 0, busy_o is 0, done_o is 0 and data_o is all zeros.
- R2: A start_i seen high at a clock edge while busy_o is low sets cnv_o and busy_o from that edge. Both stay high until the edge that raises done_o.
- R3: With turbo_i low at start, cs_no stays high and sclk_o stays low for exactly ceil(T_NORM_NS*1000/CLK_PERIOD_PS) cycles after cnv_o rises, and only then does cs_no fall.
- R4: With turbo_i high at start, the same window lasts exactly ceil(T_TURBO_NS*1000/CLK_PERIOD_PS) cycles.
- R5: While cs_no is low, sclk_o gives exactly DATA_W high pulses, each SCLK_HALF cycles high and SCLK_HALF cycles low. sclk_o is low whenever cs_no is high. The bit present on sdo_i at each falling edge is taken, first bit as MSB.
- R6: cs_no returns high one cycle before cnv_o falls. done_o is high for exactly the one cycle in which cnv_o has just fallen and busy_o is low.
- R7: When SIGNED_RES is 0, data_o holds the captured word in its low DATA_W bits and zeros above them.
- R8: When SIGNED_RES is 1, data_o holds the captured word with bit DATA_W-1 copied into every bit above it. The container width is 32 when DATA_W exceeds 16, else 16.
- R9: start_i raised while busy_o is high has no effect: no new cycle follows the current one, so cnv_o and busy_o stay low after done.
- R10: data_o keeps its value from the done cycle until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion cycle |
| turbo_i | input | 1 | Select the shorter conversion wait (sampled at start) |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert strobe to the converter |
| cs_no | output | 1 | Active-low select to the converter's select/data-in pin |
| sclk_o | output | 1 | Serial clock, idle low |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle pulse when data_o is updated |
| data_o | output | OUT_W | Extended result (16 or 32 bits) |

## Verification
The bench runs two configurations: 14-bit unsigned and 18-bit signed. In each it measures the length of the select-inactive window in both wait modes. A controller that rounded the cycle count down or latched turbo at the wrong time would produce a window shorter or longer than the bench expects. The bench counts serial clock pulses and feeds words whose top bit is set. An off-by-one bit counter or a bit-reversed shift would give a wrong value, and a missing sign extension would leave the upper container bits zero for a negative result. It also raises start in the middle of a readout, where a controller that accepted it would start a second cycle straight after done. Finally it checks that select rises before the convert strobe falls and that done lasts a single cycle.

// File: rtl/sar4w_pkg.sv
package sar4w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } cap_state_e;

  function automatic int ceil_cycles(input int t_ns, input int period_ps);
    return (t_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/sar4w_conv_timer.sv
module sar4w_conv_timer #(
  parameter int NORM_CYC  = 42,
  parameter int TURBO_CYC = 32,
  parameter int CNT_W     = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic turbo_i,
  input  logic run_i,
  output logic expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= turbo_i ? CNT_W'(TURBO_CYC - 1) : CNT_W'(NORM_CYC - 1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/sar4w_shifter.sv
module sar4w_shifter #(
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              last_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int DIV_W = (2 * SCLK_HALF > 2) ? $clog2(2 * SCLK_HALF) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] word_q;
  logic              sample;

  // falling edge of sclk_o coincides with the sampling edge
  assign sample = en_i && (div_q == DIV_W'(SCLK_HALF - 1));
  assign sclk_o = en_i && (div_q < DIV_W'(SCLK_HALF));
  assign last_o = sample && (bit_q == BIT_W'(DATA_W - 1));
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      word_q <= '0;
    end else if (!en_i) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= (div_q == DIV_W'(2 * SCLK_HALF - 1)) ? '0 : div_q + 1'b1;
      if (sample) begin
        word_q <= {word_q[DATA_W-2:0], sdo_i};
        bit_q  <= bit_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar4w_extend.sv
module sar4w_extend #(
  parameter int DATA_W     = 16,
  parameter int OUT_W      = 16,
  parameter bit SIGNED_RES = 1'b0
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [OUT_W-1:0]  data_o
);

  generate
    if (OUT_W == DATA_W) begin : g_same
      assign data_o = word_i;
    end else if (SIGNED_RES) begin : g_sext
      assign data_o = {{(OUT_W - DATA_W){word_i[DATA_W-1]}}, word_i};
    end else begin : g_zext
      assign data_o = {{(OUT_W - DATA_W){1'b0}}, word_i};
    end
  endgenerate

endmodule

// File: rtl/sar4w_capture.sv
module sar4w_capture
  import sar4w_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_NORM_NS     = 420,
  parameter int T_TURBO_NS    = 320,
  parameter int DATA_W        = 16,
  parameter bit SIGNED_RES    = 1'b0,
  parameter int SCLK_HALF     = 2,
  localparam int OUT_W        = (DATA_W > 16) ? 32 : 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             turbo_i,
  input  logic             sdo_i,
  output logic             cnv_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] data_o
);

  localparam int NORM_CYC  = ceil_cycles(T_NORM_NS, CLK_PERIOD_PS);
  localparam int TURBO_CYC = ceil_cycles(T_TURBO_NS, CLK_PERIOD_PS);
  localparam int MAX_CYC   = (NORM_CYC > TURBO_CYC) ? NORM_CYC : TURBO_CYC;
  localparam int MIN_CYC   = (NORM_CYC < TURBO_CYC) ? NORM_CYC : TURBO_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  cap_state_e        state_q, state_d;
  logic              accept, expire, last_bit;
  logic [DATA_W-1:0] word;
  logic [OUT_W-1:0]  ext_word;
  logic [OUT_W-1:0]  data_q;
  logic              done_q;

  assign accept = (state_q == ST_IDLE) && start_i;

  sar4w_conv_timer #(
    .NORM_CYC (NORM_CYC),
    .TURBO_CYC(TURBO_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .turbo_i (turbo_i),
    .run_i   (state_q == ST_CONV),
    .expire_o(expire)
  );

  sar4w_shifter #(
    .DATA_W   (DATA_W),
    .SCLK_HALF(SCLK_HALF)
  ) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_SHIFT),
    .sdo_i (sdo_i),
    .sclk_o(sclk_o),
    .last_o(last_bit),
    .word_o(word)
  );

  sar4w_extend #(
    .DATA_W    (DATA_W),
    .OUT_W     (OUT_W),
    .SIGNED_RES(SIGNED_RES)
  ) u_ext (
    .word_i(word),
    .data_o(ext_word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_CONV;
      ST_CONV:  if (expire)   state_d = ST_SHIFT;
      ST_SHIFT: if (last_bit) state_d = ST_TAIL;
      ST_TAIL:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TAIL);
      if (state_q == ST_TAIL) data_q <= ext_word;
    end
  end

  assign cnv_o  = (state_q != ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);
  assign cs_no  = (state_q != ST_SHIFT);
  assign done_o = done_q;
  assign data_o = data_q;

endmodule

// File: rtl/sar4w_capture_chk.sv
module sar4w_capture_chk #(
  parameter int MIN_CYC = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cnv_o,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o
);

  logic [15:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_q <= '0;
    else if (!cnv_o)       win_q <= '0;
    else if (cs_no && win_q != 16'hffff) win_q <= win_q + 1'b1;
  end

  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && cnv_o); // R2

  AST_CS_INSIDE_CNV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> cnv_o); // R2

  AST_CONV_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> win_q >= 16'(MIN_CYC)); // R3

  AST_SCLK_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R5

  AST_CS_BEFORE_CNV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> cs_no && $past(cs_no)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R6

endmodule

bind sar4w_capture sar4w_capture_chk #(.MIN_CYC(MIN_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cnv_o  (cnv_o),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/sar4w_capture_tb_top.sv
module sar4w_capture_tb_top;

  localparam int CLK_NS = 10;
  localparam int W0 = 14;
  localparam int W1 = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start [2];
  logic turbo [2];
  logic sdo   [2];
  logic cnv   [2];
  logic cs_n  [2];
  logic sclk  [2];
  logic busy  [2];
  logic done  [2];
  logic [15:0] data0;
  logic [31:0] data1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sar4w_capture #(
    .CLK_PERIOD_PS(CLK_NS * 1000), .T_NORM_NS(420), .T_TURBO_NS(320),
    .DATA_W(W0), .SIGNED_RES(1'b0), .SCLK_HALF(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[0]), .turbo_i(turbo[0]),
    .sdo_i(sdo[0]), .cnv_o(cnv[0]), .cs_no(cs_n[0]), .sclk_o(sclk[0]),
    .busy_o(busy[0]), .done_o(done[0]), .data_o(data0)
  );

  sar4w_capture #(
    .CLK_PERIOD_PS(CLK_NS * 1000), .T_NORM_NS(500), .T_TURBO_NS(400),
    .DATA_W(W1), .SIGNED_RES(1'b1), .SCLK_HALF(1)
  ) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start[1]), .turbo_i(turbo[1]),
    .sdo_i(sdo[1]), .cnv_o(cnv[1]), .cs_no(cs_n[1]), .sclk_o(sclk[1]),
    .busy_o(busy[1]), .done_o(done[1]), .data_o(data1)
  );

  // converter models: launch a bit on each rising serial clock, MSB first
  logic [31:0] word_m [2];
  int idx_m [2];
  always @(negedge cs_n[0]) idx_m[0] = W0 - 1;
  always @(posedge sclk[0]) begin sdo[0] = word_m[0][idx_m[0]]; idx_m[0]--; end
  always @(negedge cs_n[1]) idx_m[1] = W1 - 1;
  always @(posedge sclk[1]) begin sdo[1] = word_m[1][idx_m[1]]; idx_m[1]--; end

  function automatic logic [31:0] get_data(input int u);
    return (u == 0) ? {16'h0, data0} : data1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic test_reset();
    for (int u = 0; u < 2; u++) begin
      chk(cnv[u] == 0 && cs_n[u] == 1 && sclk[u] == 0, "R1", "pins after reset",
          {29'h0, cnv[u], cs_n[u], sclk[u]}, 32'h2);
      chk(busy[u] == 0 && done[u] == 0 && get_data(u) == 0, "R1", "status after reset",
          get_data(u), 32'h0);
    end
  endtask

  // one full cycle; exp_wait in clock cycles
  task automatic run_conv(input int u, input bit tb, input logic [31:0] word,
                          input int w, input int exp_wait, input logic [31:0] exp_data,
                          input string wreq, input string dreq, input bit poke);
    int n = 0;
    int pulses = 0;
    bit prev = 0;
    bit cnv_lost = 0;
    bit poked = 0;
    word_m[u] = word;
    turbo[u] = tb;
    @(negedge clk) start[u] = 1;
    @(negedge clk) start[u] = 0;
    chk(cnv[u] && busy[u], "R2", "cnv/busy after start", {30'h0, cnv[u], busy[u]}, 32'h3);
    while (cs_n[u] && n < 1000) begin
      if (sclk[u]) cnv_lost = 1;
      n++;
      @(negedge clk);
    end
    chk(n == exp_wait && !cnv_lost, wreq, "select-inactive window", n, exp_wait);
    while (!cs_n[u] && pulses < 100) begin
      if (sclk[u] && !prev) pulses++;
      if (!cnv[u] || !busy[u]) cnv_lost = 1;
      prev = sclk[u];
      if (poke && pulses == 2 && !poked) begin start[u] = 1; poked = 1; end
      else start[u] = 0;
      @(negedge clk);
    end
    start[u] = 0;
    chk(pulses == w, "R5", "serial clock pulses", pulses, w);
    chk(!cnv_lost, "R2", "cnv held during readout", cnv_lost, 0);
    chk(cnv[u] && !done[u] && !sclk[u], "R6", "select released before cnv",
        {30'h0, cnv[u], done[u]}, 32'h2);
    @(negedge clk);
    chk(done[u] && !cnv[u] && !busy[u], "R6", "done with cnv low",
        {29'h0, done[u], cnv[u], busy[u]}, 32'h4);
    chk(get_data(u) == exp_data, dreq, "result", get_data(u), exp_data);
    @(negedge clk);
    chk(!done[u], "R6", "done single cycle", done[u], 0);
    if (poke) begin
      bit restarted = 0;
      for (int i = 0; i < 5; i++) begin
        if (busy[u] || cnv[u]) restarted = 1;
        @(negedge clk);
      end
      chk(!restarted, "R9", "start while busy ignored", restarted, 0);
    end
    chk(get_data(u) == exp_data, "R10", "result held", get_data(u), exp_data);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      start[u] = 0; turbo[u] = 0; sdo[u] = 0; word_m[u] = '0; idx_m[u] = 0;
    end
    #(CLK_NS * 3);
    @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    // 14-bit unsigned: normal 42 cycles, turbo 32 cycles
    run_conv(0, 0, 32'h2ABC, W0, 42, 32'h0000_2ABC, "R3", "R7", 0);
    run_conv(0, 1, 32'h1357, W0, 32, 32'h0000_1357, "R4", "R7", 1);
    // 18-bit signed: normal 50 cycles, turbo 40 cycles
    run_conv(1, 0, 32'h2_0001, W1, 50, 32'hFFFE_0001, "R3", "R8", 0);
    run_conv(1, 1, 32'h1_2345, W1, 40, 32'h0001_2345, "R4", "R8", 1);
    run_conv(1, 1, 32'h3_FFFF, W1, 40, 32'hFFFF_FFFF, "R4", "R8", 0);
    summary();
  end

endmodule